// File: doc/BRIEF.md
# Multiplexed Bus Machine-Cycle Sequencer

This block runs one external bus transaction at a time for an 8-bit processor core that has a 16-bit address space and shares its low address byte with its data byte on the same pins. The core asks for a transaction by giving a cycle kind, an address and, for writes, a data byte. The sequencer then steps through clock-wide T-states. In the first T-state it puts the address out and pulses an address-latch strobe, so that an external latch can hold the low byte. It then turns the shared pins over to data, drives the status and strobe lines, and finally returns the byte it read together with a one-clock completion pulse.

A slow device can hold the transaction open by pulling the ready input low. The sequencer then repeats a wait T-state for as many clocks as the device needs. Another bus master can take the bus by raising the hold input. Any transaction already in flight runs to its end. After that every bus output is released and the grant output goes high, and the bus is taken back once the hold input falls.

Top module: `busCycleSeq`

## Requirements
- R1: After reset, no transaction is running. rdN and wrN are 1, ale is 0, adOe is 0, cycDone is 0, hlda is 0 and busOe is 1.
- R2: Cycle kind codes on reqType are 0 opcode fetch, 1 memory read, 2 memory write, 3 IO read and 4 IO write. A request with a legal code is taken (reqTaken high) when no transaction or bus release is active and hold is low. Codes 5 to 7 are ignored: reqTaken stays 0 and no ale pulse follows.
- R3: In the first T-state ale is high for exactly one clock and adOut carries address bits 7:0 with adOe high. For memory kinds addrHi carries address bits 15:8. For IO kinds addrHi repeats the 8-bit port address (address bits 7:0).
- R4: From the first to the last T-state, {ioM,s1,s0} shows 3'b011 for opcode fetch, 3'b010 for memory read, 3'b001 for memory write, 3'b110 for IO read and 3'b101 for IO write.
- R5: With ready high, an opcode fetch lasts 4 T-states and every other kind lasts 3. cycDone pulses for one clock in the clock after the last T-state.
- R6: For read kinds rdN is low in T2, in every wait state and in T3, and adOe is low in those clocks. For write kinds wrN is low in the same clocks, with adOut equal to the write byte and adOe high.
- R7: ready is sampled at the end of T2 and at the end of each wait state. Each low sample adds one wait T-state with the strobe held low.
- R8: For read kinds, the adIn value present at the end of T3 (the edge where rdN rises) appears on rdData while cycDone is high. rdData keeps that value through later write cycles.
- R9: hold is acted on only between transactions. A transaction in progress completes with its normal length. The clock after that, hlda is 1, busOe is 0, adOe is 0, ale is 0 and rdN/wrN are 1, and no request is taken. One clock after hold falls, hlda is 0 and requests are taken again.
- R10: rdN and wrN are never low in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period is one T-state |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Transaction request present |
| reqType | input | 3 | Cycle kind code |
| reqAddr | input | 16 | Transaction address |
| reqWdata | input | 8 | Byte to write |
| reqTaken | output | 1 | Request accepted this clock |
| rdData | output | 8 | Last byte read |
| cycDone | output | 1 | One-clock completion pulse |
| ready | input | 1 | Device ready; low inserts wait states |
| hold | input | 1 | Bus release request from another master |
| hlda | output | 1 | Bus released |
| addrHi | output | 8 | High address byte pins |
| adOut | output | 8 | Value driven on the shared address/data pins |
| adIn | input | 8 | Value read from the shared address/data pins |
| adOe | output | 1 | Output enable for the shared pins |
| busOe | output | 1 | Output enable for addrHi, ale and status/strobe pins |
| ale | output | 1 | Address latch strobe |
| ioM | output | 1 | 1 for IO kinds, 0 for memory kinds |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| rdN | output | 1 | Active-low read strobe |
| wrN | output | 1 | Active-low write strobe |

## Verification
The assertions assume that hold and ready change only between clock edges. They also assume that the requester keeps reqValid and its fields steady until reqTaken is seen. The bench drives every input at the falling edge, drops reqValid in the clock after acceptance, and raises hold only in the idle gap or in mid-transaction. Random wait counts stay between 0 and 3, so every stall is finite, and random cycle kinds are drawn only from the legal codes. Illegal codes are presented in a separate directed case.

// File: rtl/busSeqPkg.sv
package busSeqPkg;
  typedef enum logic [2:0] {
    CYC_FETCH = 3'd0,
    CYC_MRD   = 3'd1,
    CYC_MWR   = 3'd2,
    CYC_IORD  = 3'd3,
    CYC_IOWR  = 3'd4
  } cycType_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_T1, PH_T2, PH_TW, PH_T3, PH_T4, PH_HOLD
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;   // capture request fields
    logic captureRd;  // capture read byte at end of T3
    logic addrPhase;  // T1: address on pins, ale high
    logic strobe;     // T2/TW/T3: read or write strobe low
    logic active;     // any T-state of a transaction
    logic floatBus;   // bus released to other master
  } seqCtl_t;

  function automatic logic typeLegal(input logic [2:0] t);
    return t <= 3'd4;
  endfunction

  function automatic logic typeIsRead(input cycType_e t);
    return (t == CYC_FETCH) || (t == CYC_MRD) || (t == CYC_IORD);
  endfunction

  function automatic logic typeIsIo(input cycType_e t);
    return (t == CYC_IORD) || (t == CYC_IOWR);
  endfunction

  // {ioM, s1, s0}
  function automatic logic [2:0] statusOf(input cycType_e t);
    case (t)
      CYC_FETCH: return 3'b011;
      CYC_MRD:   return 3'b010;
      CYC_MWR:   return 3'b001;
      CYC_IORD:  return 3'b110;
      CYC_IOWR:  return 3'b101;
      default:   return 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/busSeqCtrl.sv
module busSeqCtrl
  import busSeqPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic [2:0] reqType,
  input  logic     ready,
  input  logic     hold,
  input  cycType_e curType,
  output seqCtl_t  ctl,
  output logic     reqTaken,
  output logic     cycDone,
  output logic     hlda
);
  phase_e phase, phaseNext;
  logic   lastPh;
  logic   doneQ;

  assign reqTaken = (phase == PH_IDLE) && !hold && reqValid && typeLegal(reqType);
  assign lastPh   = ((phase == PH_T3) && (curType != CYC_FETCH)) || (phase == PH_T4);

  always_comb begin
    phaseNext = phase;
    case (phase)
      PH_IDLE: begin
        if (hold)          phaseNext = PH_HOLD;
        else if (reqTaken) phaseNext = PH_T1;
      end
      PH_T1:   phaseNext = PH_T2;
      PH_T2:   phaseNext = ready ? PH_T3 : PH_TW;
      PH_TW:   phaseNext = ready ? PH_T3 : PH_TW;
      PH_T3:   phaseNext = (curType == CYC_FETCH) ? PH_T4 : PH_IDLE;
      PH_T4:   phaseNext = PH_IDLE;
      PH_HOLD: phaseNext = hold ? PH_HOLD : PH_IDLE;
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      doneQ <= 1'b0;
    end else begin
      phase <= phaseNext;
      doneQ <= lastPh;
    end
  end

  always_comb begin
    ctl.latchReq  = reqTaken;
    ctl.captureRd = (phase == PH_T3) && typeIsRead(curType);
    ctl.addrPhase = (phase == PH_T1);
    ctl.strobe    = (phase == PH_T2) || (phase == PH_TW) || (phase == PH_T3);
    ctl.active    = (phase == PH_T1) || ctl.strobe || (phase == PH_T4);
    ctl.floatBus  = (phase == PH_HOLD);
  end

  assign cycDone = doneQ;
  assign hlda    = (phase == PH_HOLD);

  // R7: a low ready sample in T2 or a wait state gives another wait state
  a_r7_wait_on_not_ready: assert property (@(posedge clk) disable iff (!rstN)
    ((phase == PH_T2 || phase == PH_TW) && !ready) |=> (phase == PH_TW));
  // R9: hold seen between transactions releases the bus next clock
  a_r9_hold_from_idle: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE && hold) |=> hlda);
  // R9: a transaction in progress is never cut short by hold
  a_r9_no_abort: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.active && !lastPh) |=> ctl.active);
  // R5: completion pulse lasts one clock
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    cycDone |=> !cycDone);
  // R2: nothing is taken while released
  a_r2_no_take_in_hold: assert property (@(posedge clk) disable iff (!rstN)
    hlda |-> !reqTaken);
endmodule

// File: rtl/busSeqDp.sv
module busSeqDp
  import busSeqPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic [2:0]        reqType,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] adIn,
  output cycType_e          curType,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-DATA_W-1:0] addrHi,
  output logic [DATA_W-1:0] adOut,
  output logic              adOe,
  output logic              busOe,
  output logic              ale,
  output logic              ioM,
  output logic              s1,
  output logic              s0,
  output logic              rdN,
  output logic              wrN
);
  localparam int HI_W = ADDR_W - DATA_W;

  cycType_e          typeQ;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdQ;
  logic              isRead, isIo;
  logic [2:0]        status;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      typeQ  <= CYC_FETCH;
      addrQ  <= '0;
      wdataQ <= '0;
      rdQ    <= '0;
    end else begin
      if (ctl.latchReq) begin
        typeQ  <= cycType_e'(reqType);
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (ctl.captureRd) rdQ <= adIn;
    end
  end

  assign isRead  = typeIsRead(typeQ);
  assign isIo    = typeIsIo(typeQ);
  assign curType = typeQ;
  assign rdData  = rdQ;

  always_comb begin
    if (!ctl.active)  addrHi = '0;
    else if (isIo)    addrHi = HI_W'(addrQ[DATA_W-1:0]);
    else              addrHi = addrQ[ADDR_W-1:DATA_W];

    if (ctl.addrPhase)                adOut = addrQ[DATA_W-1:0];
    else if (ctl.strobe && !isRead)   adOut = wdataQ;
    else                              adOut = '0;

    adOe   = ctl.addrPhase || (ctl.strobe && !isRead);
    status = ctl.active ? statusOf(typeQ) : 3'b000;
  end

  assign {ioM, s1, s0} = status;
  assign ale   = ctl.addrPhase;
  assign rdN   = !(ctl.strobe && isRead);
  assign wrN   = !(ctl.strobe && !isRead);
  assign busOe = !ctl.floatBus;

  // R10: strobes never overlap
  a_r10_strobe_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !wrN));
  // R9: released bus drives nothing and shows no strobes
  a_r9_float_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busOe |-> (rdN && wrN && !adOe && !ale));
  // R3: address latch strobe is a single clock
  a_r3_ale_single: assert property (@(posedge clk) disable iff (!rstN)
    ale |=> !ale);
  // R4: status stays put across the T-states of one transaction
  a_r4_status_stable: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.active && !ctl.addrPhase) |-> $stable({ioM, s1, s0}));
  // R6: shared pins are not driven while a device is reading onto them
  a_r6_no_contention: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> !adOe);
endmodule

// File: rtl/busCycleSeq.sv
module busCycleSeq
  import busSeqPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqType,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqTaken,
  output logic [DATA_W-1:0] rdData,
  output logic              cycDone,
  input  logic              ready,
  input  logic              hold,
  output logic              hlda,
  output logic [ADDR_W-DATA_W-1:0] addrHi,
  output logic [DATA_W-1:0] adOut,
  input  logic [DATA_W-1:0] adIn,
  output logic              adOe,
  output logic              busOe,
  output logic              ale,
  output logic              ioM,
  output logic              s1,
  output logic              s0,
  output logic              rdN,
  output logic              wrN
);
  seqCtl_t  ctl;
  cycType_e curType;

  busSeqCtrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqType(reqType),
    .ready(ready), .hold(hold), .curType(curType), .ctl(ctl),
    .reqTaken(reqTaken), .cycDone(cycDone), .hlda(hlda)
  );

  busSeqDp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqType(reqType),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .adIn(adIn),
    .curType(curType), .rdData(rdData), .addrHi(addrHi), .adOut(adOut),
    .adOe(adOe), .busOe(busOe), .ale(ale), .ioM(ioM), .s1(s1), .s0(s0),
    .rdN(rdN), .wrN(wrN)
  );
endmodule

// File: tb/tb_busCycleSeq.sv
module tb_busCycleSeq;
  logic clk = 0, rstN = 0;
  logic reqValid = 0, ready = 1, hold = 0;
  logic [2:0] reqType = 0;
  logic [15:0] reqAddr = 0;
  logic [7:0] reqWdata = 0, adIn = 8'hEE;
  logic reqTaken, cycDone, hlda, adOe, busOe, ale, ioM, s1, s0, rdN, wrN;
  logic [7:0] rdData, addrHi, adOut;
  int checks = 0, failures = 0;
  bit finished = 0;
  logic [7:0] lastRd = 0;

  always #4 clk = ~clk;

  busCycleSeq dut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] memByte(input logic [2:0] t, input logic [15:0] a);
    return (t >= 3) ? (a[7:0] ^ 8'hC3) : (a[7:0] ^ a[15:8] ^ 8'h5A);
  endfunction
  function automatic logic [2:0] expStatus(input logic [2:0] t);
    case (t)
      0: return 3'b011; 1: return 3'b010; 2: return 3'b001;
      3: return 3'b110; default: return 3'b101;
    endcase
  endfunction
  function automatic bit isRd(input logic [2:0] t);
    return (t == 0) || (t == 1) || (t == 3);
  endfunction

  task automatic runCycle(input logic [2:0] t, input logic [15:0] a,
                          input logic [7:0] wd, input int waits, input bit holdMid);
    int tCount, strobeCount, aleCount, left, expT;
    bit doneSeen;
    @(negedge clk);
    reqValid = 1; reqType = t; reqAddr = a; reqWdata = wd; ready = 1;
    #1 chk(reqTaken === 1'b1, "R2", "reqTaken legal", reqTaken, 1);
    @(negedge clk);
    reqValid = 0; reqType = 3'd7;
    // T1
    tCount = 1; strobeCount = 0; aleCount = 0; left = waits; doneSeen = 0;
    chk(ale === 1'b1, "R3", "ale in T1", ale, 1);
    chk(adOut === a[7:0] && adOe === 1'b1, "R3", "low addr in T1", adOut, a[7:0]);
    chk(addrHi === ((t >= 3) ? a[7:0] : a[15:8]), "R3", "addrHi",
        addrHi, (t >= 3) ? a[7:0] : a[15:8]);
    chk({ioM, s1, s0} === expStatus(t), "R4", "status T1", {ioM, s1, s0}, expStatus(t));
    chk(rdN === 1'b1 && wrN === 1'b1, "R6", "no strobe in T1", {rdN, wrN}, 2'b11);
    aleCount = 1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (cycDone === 1'b1) begin doneSeen = 1; break; end
      tCount++;
      if (ale === 1'b1) aleCount++;
      chk({ioM, s1, s0} === expStatus(t), "R4", "status held", {ioM, s1, s0}, expStatus(t));
      chk(!(rdN === 1'b0 && wrN === 1'b0), "R10", "strobe overlap", {rdN, wrN}, 2'b11);
      if (rdN === 1'b0 || wrN === 1'b0) begin
        strobeCount++;
        if (isRd(t)) chk(rdN === 1'b0 && adOe === 1'b0, "R6", "read strobe/oe", {rdN, adOe}, 0);
        else chk(wrN === 1'b0 && adOe === 1'b1 && adOut === wd, "R6", "write data",
                 adOut, wd);
      end
      if (holdMid && tCount == 2) hold = 1;
      if ((rdN === 1'b0 || wrN === 1'b0) && left > 0) begin ready = 0; left--; end
      else ready = 1;
      adIn = (rdN === 1'b0) ? memByte(t, a) : 8'hEE;
    end
    adIn = 8'hEE; ready = 1;
    expT = ((t == 0) ? 4 : 3) + waits;
    chk(doneSeen, "R5", "cycDone seen", doneSeen, 1);
    chk(tCount == expT, "R5", "T-state count", tCount, expT);
    chk(strobeCount == 2 + waits, "R7", "strobe clocks with waits", strobeCount, 2 + waits);
    chk(aleCount == 1, "R3", "single ale", aleCount, 1);
    if (isRd(t)) lastRd = memByte(t, a);
    chk(rdData === lastRd, "R8", "rdData", rdData, lastRd);
    @(negedge clk);
    chk(cycDone === 1'b0, "R5", "done one clock", cycDone, 0);
    if (holdMid) begin
      chk(hlda === 1'b1 && busOe === 1'b0 && adOe === 1'b0 && rdN && wrN && !ale,
          "R9", "bus released after cycle", hlda, 1);
      reqValid = 1; reqType = 3'd1;
      #1 chk(reqTaken === 1'b0, "R9", "no take in hold", reqTaken, 0);
      @(negedge clk);
      chk(hlda === 1'b1, "R9", "hlda held", hlda, 1);
      reqValid = 0; hold = 0;
      @(negedge clk);
      chk(hlda === 1'b0 && busOe === 1'b1, "R9", "bus regained", hlda, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk(rdN === 1 && wrN === 1 && ale === 0 && adOe === 0 && cycDone === 0 &&
        hlda === 0 && busOe === 1, "R1", "reset state", {rdN, wrN, ale, adOe}, 4'b1100);
    rstN = 1;
    @(negedge clk);
    // R2: illegal codes ignored
    for (int c = 5; c < 8; c++) begin
      reqValid = 1; reqType = 3'(c); reqAddr = 16'h1234;
      #1 chk(reqTaken === 1'b0, "R2", "illegal code taken", reqTaken, 0);
      @(negedge clk);
      chk(ale === 1'b0, "R2", "no ale on illegal code", ale, 0);
    end
    reqValid = 0;
    // directed corners
    runCycle(3'd0, 16'h2005, 8'h00, 0, 0);
    runCycle(3'd1, 16'h8800, 8'h00, 0, 0);
    runCycle(3'd2, 16'h8FFF, 8'hA5, 2, 0);
    runCycle(3'd3, 16'h0030, 8'h00, 3, 0);
    runCycle(3'd4, 16'h0050, 8'h3C, 0, 0);
    runCycle(3'd0, 16'hFFFF, 8'h00, 1, 1);
    runCycle(3'd2, 16'h0001, 8'h7E, 0, 1);
    // R9: hold between transactions
    @(negedge clk); hold = 1;
    @(negedge clk);
    chk(hlda === 1'b1 && busOe === 1'b0, "R9", "idle hold", hlda, 1);
    hold = 0;
    @(negedge clk);
    chk(hlda === 1'b0, "R9", "idle hold release", hlda, 0);
    // random
    for (int n = 0; n < 150; n++) begin
      logic [2:0] t;
      t = 3'($urandom % 5);
      runCycle(t, 16'($urandom), 8'($urandom), ($urandom % 3 == 0) ? int'($urandom % 4) : 0,
               ($urandom % 10) == 0);
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule